// File: doc/BRIEF.md
# Configurable Register Field

This block is one software-visible register field of parameterizable width. Parameters choose what a software write and a software read do to the stored value. Hardware can update the field through its own port with per-bit control. The block drives the field value and status pulses back to the surrounding logic. Address decoding, bus protocol handling and the packing of several fields into one register are left to the logic around it.

Software reaches the field through a select, a read strobe, a write strobe, write data and a write-enable input. Read data is combinational. It carries the field value from before any read side effect, and it is zero when no read is selected. Hardware drives a next value, a write-enable and a per-bit vector. A parameter decides whether that vector enables bits or masks them. Hardware also has separate clear and set strobes.

The write-mode encoding is `WR_MODE`:

| Value | Write effect |
|---|---|
| 0 | plain write |
| 1 | clear bits written 1 |
| 2 | set bits written 1 |
| 3 | toggle bits written 1 |
| 4 | clear bits written 0 |
| 5 | set bits written 0 |
| 6 | toggle bits written 0 |
| 7 | any write clears |
| 8 | any write sets |

The read-mode encoding is `RD_MODE`:

| Value | Read effect |
|---|---|
| 0 | none |
| 1 | clear on read |
| 2 | set on read |

Top module: `regfield`

## Requirements
- R1: A software write applies the effect that `WR_MODE` selects (0 to 8, as in the table above). The effect is computed from the old value and `wdata` and appears on `q` at the next clock edge.
- R2: A selected read applies the effect that `RD_MODE` selects (0 none, 1 clear to zero, 2 set to all ones). `rdata` returns the value from before that effect, and `rdata` is zero whenever `sel && rd` is low.
- R3: With `PULSE` set, a write loads `wdata` for exactly one cycle. The field is zero in every cycle that follows a cycle without a software write.
- R4: A software write takes effect only when `sw_we` is at its active level: high, or low when `SW_WE_LOW` is set. A blocked write leaves the field unchanged.
- R5: A hardware update takes effect only when `HW_PATH` is set and `hw_we` is at its active level: high, or low when `HW_WE_LOW` is set. It changes only the bits whose `hw_bits` value is 1 when `BITVEC_IS_MASK` is 0, or 0 when `BITVEC_IS_MASK` is 1.
- R6: `hw_clr` forces all zeros and `hw_set` forces all ones, even when `HW_PATH` is 0. Clear wins over set, and both win over the hardware next value.
- R7: Priority, from highest to lowest: software write, read side effect, hardware strobes, hardware update.
- R8: `sw_acc` is high in the same cycle as any selected read or write. `sw_mod` is high in the same cycle as an enabled write, or as a read whose read mode changes the field.
- R9: `all_ones`, `any_one` and `parity` give the AND, the OR and the XOR of the current field bits.
- R10: A synchronous active-high `rst` loads `RST_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| sel | input | 1 | field selected by the bus decoder |
| rd | input | 1 | read strobe |
| wr | input | 1 | write strobe |
| wdata | input | W | write data |
| sw_we | input | 1 | software write enable, polarity set by parameter |
| rdata | output | W | read data, zero when not read |
| hw_next | input | W | hardware next value |
| hw_we | input | 1 | hardware write enable, polarity set by parameter |
| hw_clr | input | 1 | hardware clear strobe |
| hw_set | input | 1 | hardware set strobe |
| hw_bits | input | W | per-bit hardware enable or mask |
| q | output | W | field value |
| sw_mod | output | 1 | field modified by software this cycle |
| sw_acc | output | 1 | field accessed by software this cycle |
| all_ones | output | 1 | AND of all field bits |
| any_one | output | 1 | OR of all field bits |
| parity | output | 1 | XOR of all field bits |

## Verification
The bench builds ten 8-bit copies that share one stimulus. Copies 0 to 8 each take one write mode, with the read mode set to the copy index modulo 3. Copy 9 is the pulse-mode build. Software and hardware enable polarity, and enable versus mask for the bit vector, alternate with the low index bits, so every polarity meets several write modes. Copy 4 has no hardware write path, which leaves only the strobes able to reach it from hardware. Each copy has a distinct reset value, and random traffic with collisions between reads, writes and strobes reaches every priority case.

// File: rtl/regfield.sv
module regfield #(
  parameter int W = 8,
  parameter int WR_MODE = 0,
  parameter int RD_MODE = 0,
  parameter bit PULSE = 1'b0,
  parameter bit SW_WE_LOW = 1'b0,
  parameter bit HW_WE_LOW = 1'b0,
  parameter bit HW_PATH = 1'b1,
  parameter bit BITVEC_IS_MASK = 1'b0,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic         rd,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         sw_we,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] hw_next,
  input  logic         hw_we,
  input  logic         hw_clr,
  input  logic         hw_set,
  input  logic [W-1:0] hw_bits,
  output logic [W-1:0] q,
  output logic         sw_mod,
  output logic         sw_acc,
  output logic         all_ones,
  output logic         any_one,
  output logic         parity
);
  localparam logic [W-1:0] ONES = '1;
  localparam bit RD_FX = (RD_MODE != 0) && !PULSE;

  logic         wr_go, rd_go, rd_fx, hw_go;
  logic [W-1:0] sw_val, hw_en;

  assign wr_go = sel && wr && (sw_we ^ SW_WE_LOW);
  assign rd_go = sel && rd;
  assign rd_fx = rd_go && RD_FX;
  assign hw_go = HW_PATH && (hw_we ^ HW_WE_LOW);
  assign hw_en = BITVEC_IS_MASK ? ~hw_bits : hw_bits;

  always_comb begin
    case (WR_MODE)
      1:       sw_val = q & ~wdata;
      2:       sw_val = q | wdata;
      3:       sw_val = q ^ wdata;
      4:       sw_val = q & wdata;
      5:       sw_val = q | ~wdata;
      6:       sw_val = q ^ ~wdata;
      7:       sw_val = '0;
      8:       sw_val = ONES;
      default: sw_val = wdata;
    endcase
  end

  generate
    if (PULSE) begin : g_pulse
      always_ff @(posedge clk) begin
        if (rst)        q <= RST_VAL;
        else if (wr_go) q <= wdata;
        else            q <= '0;
      end
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (rst)         q <= RST_VAL;
        else if (wr_go)  q <= sw_val;
        else if (rd_fx)  q <= (RD_MODE == 1) ? '0 : ONES;
        else if (hw_clr) q <= '0;
        else if (hw_set) q <= ONES;
        else if (hw_go)  q <= (q & ~hw_en) | (hw_next & hw_en);
      end
    end
  endgenerate

  assign rdata    = rd_go ? q : '0;
  assign sw_acc   = sel && (rd || wr);
  assign sw_mod   = wr_go || rd_fx;
  assign all_ones = &q;
  assign any_one  = |q;
  assign parity   = ^q;
endmodule

// File: rtl/regfield_checker.sv
module regfield_checker #(
  parameter int W = 8,
  parameter bit PULSE = 1'b0,
  parameter bit HW_WE_LOW = 1'b0,
  parameter bit HW_PATH = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input logic         clk,
  input logic         rst,
  input logic         sel,
  input logic         rd,
  input logic         wr,
  input logic         hw_we,
  input logic         hw_clr,
  input logic         hw_set,
  input logic [W-1:0] rdata,
  input logic [W-1:0] q,
  input logic         sw_mod,
  input logic         sw_acc,
  input logic         all_ones,
  input logic         any_one
);
  AST_RESET_LOADS: assert property (@(posedge clk) rst |=> (rst || q == RST_VAL)); // R10
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
    (PULSE && !(sel && wr)) |=> q == '0); // R3
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(sel && rd) |-> rdata == '0); // R2
  AST_ACC_ON_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (sel && (rd || wr)) |-> sw_acc); // R8
  AST_MOD_NEEDS_ACC: assert property (@(posedge clk) disable iff (rst)
    sw_mod |-> sw_acc); // R8
  AST_CLR_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!PULSE && hw_clr && !(sel && (rd || wr))) |=> q == '0); // R6
  AST_SET_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!PULSE && hw_set && !hw_clr && !(sel && (rd || wr))) |=> q == '1); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!PULSE && !(sel && (rd || wr)) && !hw_clr && !hw_set && !(HW_PATH && (hw_we ^ HW_WE_LOW)))
    |=> $stable(q)); // R5
  AST_AND_IMPLIES_OR: assert property (@(posedge clk) disable iff (rst)
    all_ones |-> any_one); // R9
endmodule

bind regfield regfield_checker #(.W(W), .PULSE(PULSE), .HW_WE_LOW(HW_WE_LOW),
  .HW_PATH(HW_PATH), .RST_VAL(RST_VAL)) u_chk (.*);

// File: tb/regfield_test.sv
module regfield_test;
  localparam int N = 10;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, sel = 1'b0, rd = 1'b0, wr = 1'b0, sw_we = 1'b0;
  logic hw_we = 1'b0, hw_clr = 1'b0, hw_set = 1'b0;
  logic [7:0] wdata = '0, hw_next = '0, hw_bits = '0;

  logic [7:0] q_o [N];
  logic [7:0] rd_o [N];
  logic mod_o [N], acc_o [N], and_o [N], or_o [N], xor_o [N];

  for (genvar m = 0; m < N; m++) begin : g
    regfield #(.W(8), .WR_MODE(m < 9 ? m : 0), .RD_MODE(m == 9 ? 0 : m % 3),
      .PULSE(1'(m == 9)), .SW_WE_LOW(1'(m % 2)), .HW_WE_LOW(1'((m / 2) % 2)),
      .HW_PATH(1'(m != 4)), .BITVEC_IS_MASK(1'((m / 4) % 2)), .RST_VAL(8'(90 + 17 * m))
    ) uut (
      .clk(clk), .rst(rst), .sel(sel), .rd(rd), .wr(wr), .wdata(wdata), .sw_we(sw_we),
      .rdata(rd_o[m]), .hw_next(hw_next), .hw_we(hw_we), .hw_clr(hw_clr), .hw_set(hw_set),
      .hw_bits(hw_bits), .q(q_o[m]), .sw_mod(mod_o[m]), .sw_acc(acc_o[m]),
      .all_ones(and_o[m]), .any_one(or_o[m]), .parity(xor_o[m]));
  end

  int errors = 0, checks = 0;
  bit valid = 0, done = 0;
  logic [7:0] mq [N];
  string cause [N];

  task automatic chk(string tag, int m, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s copy %0d: actual %0h expected %0h", tag, m, act, exp);
    end
  endtask

  function automatic logic [7:0] wr_eff(int wm, logic [7:0] v, logic [7:0] d);
    case (wm)
      1: return v & ~d;  2: return v | d;  3: return v ^ d;
      4: return v & d;   5: return v | ~d; 6: return v ^ ~d;
      7: return 8'h00;   8: return 8'hFF;
      default: return d;
    endcase
  endfunction

  task automatic step();
    logic [7:0] nq [N];
    string nc [N];
    #1;
    for (int m = 0; m < N; m++) begin
      int rm = (m == 9) ? 0 : m % 3;
      bit pulse = (m == 9);
      bit wgo = sel && wr && (sw_we ^ (m % 2 == 1));
      bit rgo = sel && rd;
      bit rfx = rgo && rm != 0 && !pulse;
      bit hgo = (m != 4) && (hw_we ^ ((m / 2) % 2 == 1));
      logic [7:0] en = ((m / 4) % 2 == 1) ? ~hw_bits : hw_bits;
      if (valid) begin
        chk(cause[m], m, q_o[m], mq[m]);
        chk("R2 rdata", m, rd_o[m], rgo ? mq[m] : 8'h00);
        chk("R8 sw_mod", m, mod_o[m], wgo || rfx);
        chk("R8 sw_acc", m, acc_o[m], sel && (rd || wr));
        chk("R9 and", m, and_o[m], mq[m] == 8'hFF);
        chk("R9 or", m, or_o[m], mq[m] != 8'h00);
        chk("R9 xor", m, xor_o[m], $countones(mq[m]) % 2);
      end
      nq[m] = mq[m];
      if (rst) begin nq[m] = 8'(90 + 17 * m); nc[m] = "R10"; end
      else if (pulse) begin nq[m] = wgo ? wdata : 8'h00; nc[m] = "R3"; end
      else if (wgo) begin
        nq[m] = wr_eff(m, mq[m], wdata);
        nc[m] = (rfx || hw_clr || hw_set || hgo) ? "R7" : "R1";
      end else if (rfx) begin
        nq[m] = (rm == 1) ? 8'h00 : 8'hFF;
        nc[m] = (hw_clr || hw_set || hgo) ? "R7" : "R2";
      end else if (hw_clr) begin nq[m] = 8'h00; nc[m] = "R6"; end
      else if (hw_set) begin nq[m] = 8'hFF; nc[m] = "R6"; end
      else if (hgo) begin nq[m] = (mq[m] & ~en) | (hw_next & en); nc[m] = "R5"; end
      else nc[m] = (sel && wr) ? "R4" : "R5";
    end
    @(posedge clk);
    #1;
    for (int m = 0; m < N; m++) begin mq[m] = nq[m]; cause[m] = nc[m]; end
    if (rst) valid = 1;
    @(negedge clk);
  endtask

  task automatic drive(bit r, bit s, bit rr, bit ww, bit we, logic [7:0] d,
                       bit hwe, bit hc, bit hs, logic [7:0] hn, logic [7:0] hb);
    rst = r; sel = s; rd = rr; wr = ww; sw_we = we; wdata = d;
    hw_we = hwe; hw_clr = hc; hw_set = hs; hw_next = hn; hw_bits = hb;
    step();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    drive(1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 8'h00, 8'h00);
    drive(0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 8'h00, 8'h00);   // R10 reset value
    drive(0, 1, 0, 1, 1, 8'h3C, 0, 0, 0, 8'h00, 8'h00);   // R1 / R4 write, high enable
    drive(0, 1, 0, 1, 0, 8'hC3, 0, 0, 0, 8'h00, 8'h00);   // R1 / R4 write, low enable
    drive(0, 1, 1, 0, 0, 8'h00, 0, 0, 0, 8'h00, 8'h00);   // R2 read side effect
    drive(0, 0, 0, 0, 0, 8'h00, 0, 1, 1, 8'h55, 8'hFF);   // R6 clear beats set
    drive(0, 0, 0, 0, 0, 8'h00, 0, 0, 1, 8'h55, 8'hFF);   // R6 set
    drive(0, 0, 0, 0, 0, 8'h00, 1, 0, 0, 8'h0F, 8'h33);   // R5 bit vector
    drive(0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 8'hF0, 8'hCC);   // R5 other polarity
    drive(0, 1, 1, 1, 1, 8'hFF, 1, 1, 0, 8'h00, 8'hFF);   // R7 collisions
    drive(0, 1, 1, 1, 0, 8'h00, 0, 0, 1, 8'h00, 8'hFF);   // R7 collisions
    drive(0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 8'h00, 8'h00);   // R3 pulse falls
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d = ($urandom % 4 == 0) ? (($urandom % 2) ? 8'hFF : 8'h00) : 8'($urandom);
      drive($urandom % 150 == 0, $urandom % 4 != 0, $urandom % 5 < 2, $urandom % 5 < 2,
            1'($urandom), d, 1'($urandom), $urandom % 10 == 0, $urandom % 10 == 0,
            8'($urandom), 8'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule